// File: doc/BRIEF.md
# Iterative AES Round Sequencer

This block is the control state machine for an iterative AES engine whose 128-bit data path finishes roughly one round per clock. It does not transform data. It sequences the registers and multiplexers around the round logic. For each block, it first loads the state and the full key. It then performs a key-addition-only cycle, followed by the middle rounds. It ends with a final round that leaves out MixColumns and writes the output register rather than the state register.

The round-key expander is shared between encryption and decryption. Decryption therefore needs the last round key of the schedule as its starting key. When a decryption is requested and no valid stored key exists, the sequencer inserts a precompute phase. No valid stored key exists after reset, or after the key has been changed. During the precompute phase, the expander runs forward over the full schedule while the cipher path stays idle, and the result is saved into the decryption-key register. Encryption never waits for this phase.

In automatic mode, a finished block waits until the consumer has taken the previous output. In manual mode, the output is always overwritten. A start request that arrives while the block is busy, including during the precompute phase, is held. It is served straight after the current block, without an idle cycle in between.

Top module: `aes_round_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `idle_o` is 1, every enable and select output is 0, and `round_o` is 0.
- R2: The load cycle follows an accepted start when no precompute is needed.
  - In the load cycle, `state_we_o`, `state_sel_in_o` and `fkey_we_o` are 1.
  - `fkey_sel_o` is 1 (initial key) for encryption and 2 (stored decryption key) for decryption.
  - `round_o` is 0.
- R3: The cycle after the load cycle has `bypass_o`=1, `state_we_o`=1, `fkey_we_o`=1 with `fkey_sel_o`=0 (expanded key), `kexp_step_o`=1 and `round_o`=0.
- R4: Middle rounds follow for 9, 11 or 13 cycles when `key_len_i` is 0, 1 or 2 (128, 192 or 256 bits).
  - Each middle-round cycle has `state_we_o`, `fkey_we_o` and `kexp_step_o` at 1, and `bypass_o` and `skip_mix_o` at 0.
  - `round_o` counts 1 up to the last middle round.
- R5: In the final round, `skip_mix_o`=1, `state_we_o`=0, `kexp_step_o`=0 and `round_o` is 10, 12 or 14. The output is written (`out_we_o`=1) in cycle 12, 14 or 16 after the clock edge that accepts the start, when nothing stalls.
- R6: `kexp_dec_o` is 1 on every expander step of a decryption block. It is 0 on steps of encryption blocks and of the precompute phase.
- R7: A decryption start when the stored decryption key is not valid (after reset, or with `key_new_i` pulsed at or before that start) runs the precompute phase first.
  - The phase has one key-load cycle (`fkey_we_o`=1, `fkey_sel_o`=1), then 10, 12 or 14 forward steps with `state_we_o`=0, then one cycle with `dkey_we_o`=1.
  - The normal block follows, so the output appears in cycle 24, 28 or 32.
- R8: Once the decryption key is saved, decryption blocks take no precompute. Encryption blocks never take one, even right after a key change.
- R9: With `manual_i`=0 and `out_free_i`=0 in the final round, the sequencer stays in the final round with `out_we_o`=0 and `round_o` unchanged. It writes the output in the cycle in which `out_free_i` becomes 1.
- R10: With `manual_i`=1, the final round writes the output in its first cycle whatever `out_free_i` is.
- R11: A start pulse received while busy, including during the precompute phase, is kept. The next block's first cycle directly follows the cycle in which the current output is written, with `idle_o` staying 0.
- R12: `idle_o` is 1 exactly in the idle state. In the cycle after an output write with no pending request, `idle_o` is 1 and no enable output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| op_dec_i | input | 1 | Operation: 0 encrypt, 1 decrypt |
| key_len_i | input | 2 | Key length: 0=128, 1=192, 2=256 |
| key_new_i | input | 1 | Pulse: initial key has been replaced |
| manual_i | input | 1 | 1 = never stall on unread output |
| out_free_i | input | 1 | Previous output has been consumed |
| state_we_o | output | 1 | State register write enable |
| state_sel_in_o | output | 1 | State source: 1 input data, 0 round result |
| fkey_we_o | output | 1 | Full-key register write enable |
| fkey_sel_o | output | 2 | Full-key source: 0 expanded, 1 initial, 2 decryption key |
| dkey_we_o | output | 1 | Decryption-key register write enable |
| bypass_o | output | 1 | Bypass SubBytes/ShiftRows/MixColumns (key add only) |
| skip_mix_o | output | 1 | Skip MixColumns (final round) |
| out_we_o | output | 1 | Output register write enable |
| round_o | output | RND_W | Expander steps done since the last key load |
| kexp_dec_o | output | 1 | Expander direction: 1 inverse |
| kexp_step_o | output | 1 | Expander step enable |
| idle_o | output | 1 | Sequencer is idle |

## Verification
The checker assumes that `key_new_i` is pulsed only while the sequencer is idle, because a key swap in the middle of a block or precompute is outside the contract. The bench pulses `key_new_i` only together with a start issued from idle. The bench also treats a change of key length as a key change. Operation and key length are captured when a start is accepted. The bench holds them steady between starts, and a chained second request reuses the same settings.

// File: rtl/aes_round_seq_pkg.sv
`timescale 1ns/1ps
package aes_round_seq_pkg;

   localparam int NR_128 = 10;
   localparam int NR_192 = 12;
   localparam int NR_256 = 14;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLOAD,
      ST_PRUN,
      ST_PSAVE,
      ST_LOAD,
      ST_INIT,
      ST_ROUND,
      ST_FINAL
   } seq_state_e;

   typedef enum logic [1:0] {
      FK_NEXT = 2'd0,
      FK_INIT = 2'd1,
      FK_DEC  = 2'd2
   } fkey_sel_e;

endpackage

// File: rtl/aes_round_ctr.sv
`timescale 1ns/1ps
module aes_round_ctr #(
   parameter int RND_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [RND_W-1:0] limit_i,
   output logic [RND_W-1:0] cnt_o,
   output logic             last_o
);
   logic [RND_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/aes_seq_req.sv
`timescale 1ns/1ps
module aes_seq_req (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic take_i,
   input  logic key_new_i,
   input  logic dkey_we_i,
   output logic req_o,
   output logic dkey_ok_o
);
   logic req_q;
   logic valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         req_q <= take_i ? 1'b0 : (req_q | start_i);
         if (key_new_i)      valid_q <= 1'b0;
         else if (dkey_we_i) valid_q <= 1'b1;
      end
   end

   assign req_o     = req_q | start_i;
   assign dkey_ok_o = valid_q & ~key_new_i;
endmodule

// File: rtl/aes_round_seq.sv
`timescale 1ns/1ps
module aes_round_seq
   import aes_round_seq_pkg::*;
#(
   parameter bit AES192_EN = 1'b1,
   parameter int RND_W     = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             op_dec_i,
   input  logic [1:0]       key_len_i,
   input  logic             key_new_i,
   input  logic             manual_i,
   input  logic             out_free_i,
   output logic             state_we_o,
   output logic             state_sel_in_o,
   output logic             fkey_we_o,
   output logic [1:0]       fkey_sel_o,
   output logic             dkey_we_o,
   output logic             bypass_o,
   output logic             skip_mix_o,
   output logic             out_we_o,
   output logic [RND_W-1:0] round_o,
   output logic             kexp_dec_o,
   output logic             kexp_step_o,
   output logic             idle_o
);
   localparam int NEED_W = $clog2(NR_256 + 1);

   if (RND_W < NEED_W) begin : g_bad_width
      $error("RND_W too narrow for the longest key schedule");
   end

   seq_state_e       st_q, st_d;
   logic             dec_q;
   logic [1:0]       klen_q;
   logic [RND_W-1:0] limit;
   logic             take, req, dkey_ok, last, clr;
   logic             pre_needed;

   // Round count per key length; the 192-bit entry exists only when enabled
   if (AES192_EN) begin : g_kl192
      always_comb begin
         case (klen_q)
            2'd0:    limit = RND_W'(NR_128);
            2'd1:    limit = RND_W'(NR_192);
            default: limit = RND_W'(NR_256);
         endcase
      end
   end else begin : g_kl_no192
      always_comb begin
         case (klen_q)
            2'd0, 2'd1: limit = RND_W'(NR_128);
            default:    limit = RND_W'(NR_256);
         endcase
      end
   end

   aes_seq_req i_req (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .take_i    (take),
      .key_new_i (key_new_i),
      .dkey_we_i (dkey_we_o),
      .req_o     (req),
      .dkey_ok_o (dkey_ok)
   );

   aes_round_ctr #(.RND_W(RND_W)) i_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .inc_i   (kexp_step_o),
      .limit_i (limit),
      .cnt_o   (round_o),
      .last_o  (last)
   );

   assign pre_needed = op_dec_i & ~dkey_ok;
   assign clr        = take | (st_q == ST_PSAVE);

   always_comb begin
      st_d           = st_q;
      take           = 1'b0;
      state_we_o     = 1'b0;
      state_sel_in_o = 1'b0;
      fkey_we_o      = 1'b0;
      fkey_sel_o     = FK_NEXT;
      dkey_we_o      = 1'b0;
      bypass_o       = 1'b0;
      skip_mix_o     = 1'b0;
      out_we_o       = 1'b0;
      kexp_step_o    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req) begin
               take = 1'b1;
               st_d = pre_needed ? ST_PLOAD : ST_LOAD;
            end
         end
         ST_PLOAD: begin
            fkey_we_o  = 1'b1;
            fkey_sel_o = FK_INIT;
            st_d       = ST_PRUN;
         end
         ST_PRUN: begin
            fkey_we_o   = 1'b1;
            kexp_step_o = 1'b1;
            if (last) st_d = ST_PSAVE;
         end
         ST_PSAVE: begin
            dkey_we_o = 1'b1;
            st_d      = ST_LOAD;
         end
         ST_LOAD: begin
            state_we_o     = 1'b1;
            state_sel_in_o = 1'b1;
            fkey_we_o      = 1'b1;
            fkey_sel_o     = dec_q ? FK_DEC : FK_INIT;
            st_d           = ST_INIT;
         end
         ST_INIT: begin
            bypass_o    = 1'b1;
            state_we_o  = 1'b1;
            fkey_we_o   = 1'b1;
            kexp_step_o = 1'b1;
            st_d        = ST_ROUND;
         end
         ST_ROUND: begin
            state_we_o  = 1'b1;
            fkey_we_o   = 1'b1;
            kexp_step_o = 1'b1;
            if (last) st_d = ST_FINAL;
         end
         ST_FINAL: begin
            skip_mix_o = 1'b1;
            if (manual_i || out_free_i) begin
               out_we_o = 1'b1;
               if (req) begin
                  take = 1'b1;
                  st_d = pre_needed ? ST_PLOAD : ST_LOAD;
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign kexp_dec_o = kexp_step_o & dec_q & (st_q != ST_PRUN);
   assign idle_o     = (st_q == ST_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         dec_q  <= 1'b0;
         klen_q <= 2'd0;
      end else begin
         st_q <= st_d;
         if (take) begin
            dec_q  <= op_dec_i;
            klen_q <= key_len_i;
         end
      end
   end
endmodule

// File: rtl/aes_round_seq_chk.sv
`timescale 1ns/1ps
module aes_round_seq_chk
   import aes_round_seq_pkg::*;
#(
   parameter int RND_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             key_new_i,
   input logic             manual_i,
   input logic             out_free_i,
   input logic             state_we_o,
   input logic             state_sel_in_o,
   input logic             fkey_we_o,
   input logic [1:0]       fkey_sel_o,
   input logic             dkey_we_o,
   input logic             bypass_o,
   input logic             skip_mix_o,
   input logic             out_we_o,
   input logic [RND_W-1:0] round_o,
   input logic             kexp_dec_o,
   input logic             kexp_step_o,
   input logic             idle_o
);
   AST_LOAD_KEY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_we_o && state_sel_in_o) |-> (fkey_we_o && fkey_sel_o != 2'd0)); // R2
   AST_LOAD_THEN_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_we_o && state_sel_in_o) |=> (bypass_o && kexp_step_o)); // R3
   AST_BYPASS_KEY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bypass_o |-> (round_o == '0 && !skip_mix_o)); // R3
   AST_ROUND_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(round_o) <= NR_256); // R4
   AST_OUT_IN_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_we_o |-> (skip_mix_o && !state_we_o && !kexp_step_o)); // R5
   AST_PRE_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kexp_step_o && !state_we_o) |-> !kexp_dec_o); // R6
   AST_DKEY_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dkey_we_o |-> ($past(kexp_step_o) && !$past(kexp_dec_o) && !state_we_o)); // R7
   AST_KEY_NEW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      key_new_i |-> idle_o); // R8
   AST_STALL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (skip_mix_o && !manual_i && !out_free_i) |-> !out_we_o); // R9
   AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (skip_mix_o && !out_we_o) |=> (skip_mix_o && $stable(round_o))); // R9
   AST_MANUAL_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (skip_mix_o && manual_i) |-> out_we_o); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o |-> !(state_we_o || fkey_we_o || out_we_o || kexp_step_o || dkey_we_o)); // R12
   AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({bypass_o, skip_mix_o, dkey_we_o, idle_o})); // R12
endmodule

bind aes_round_seq aes_round_seq_chk #(.RND_W(RND_W)) i_aes_round_seq_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .key_new_i      (key_new_i),
   .manual_i       (manual_i),
   .out_free_i     (out_free_i),
   .state_we_o     (state_we_o),
   .state_sel_in_o (state_sel_in_o),
   .fkey_we_o      (fkey_we_o),
   .fkey_sel_o     (fkey_sel_o),
   .dkey_we_o      (dkey_we_o),
   .bypass_o       (bypass_o),
   .skip_mix_o     (skip_mix_o),
   .out_we_o       (out_we_o),
   .round_o        (round_o),
   .kexp_dec_o     (kexp_dec_o),
   .kexp_step_o    (kexp_step_o),
   .idle_o         (idle_o)
);

// File: tb/test_aes_round_seq.sv
`timescale 1ns/1ps
module test_aes_round_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, op_dec = 1'b0, key_new = 1'b0, manual = 1'b0, out_free = 1'b1;
   logic [1:0] key_len = 2'd0;
   logic       state_we, state_sel_in, fkey_we, dkey_we, bypass, skip_mix, out_we;
   logic       kexp_dec, kexp_step, idle;
   logic [1:0] fkey_sel;
   logic [3:0] round;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   bit  bvalid = 1'b0;
   logic [1:0] last_kl = 2'd0;

   always #2.5 clk = ~clk;

   aes_round_seq i_aes_round_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_dec_i(op_dec),
      .key_len_i(key_len), .key_new_i(key_new), .manual_i(manual),
      .out_free_i(out_free), .state_we_o(state_we), .state_sel_in_o(state_sel_in),
      .fkey_we_o(fkey_we), .fkey_sel_o(fkey_sel), .dkey_we_o(dkey_we),
      .bypass_o(bypass), .skip_mix_o(skip_mix), .out_we_o(out_we),
      .round_o(round), .kexp_dec_o(kexp_dec), .kexp_step_o(kexp_step), .idle_o(idle)
   );

   // Vector: [15] idle [14] state_we [13] sel_in [12] fkey_we [11:10] fkey_sel
   // [9] dkey_we [8] bypass [7] skip_mix [6] out_we [5] kexp_dec [4] step [3:0] round
   function automatic logic [15:0] got_vec();
      return {idle, state_we, state_sel_in, fkey_we, fkey_sel, dkey_we, bypass,
              skip_mix, out_we, kexp_dec, kexp_step, round};
   endfunction

   function automatic logic [15:0] exp_at(int idx, int base, bit pre, bit op, int nr, int outidx);
      logic [15:0] v = '0;
      int rel = idx - base;
      int off = pre ? nr + 2 : 0;
      if (pre && rel == 1) begin
         v[12] = 1'b1; v[11:10] = 2'd1;
      end else if (pre && rel >= 2 && rel <= nr + 1) begin
         v[12] = 1'b1; v[4] = 1'b1; v[3:0] = 4'(rel - 2);
      end else if (pre && rel == nr + 2) begin
         v[9] = 1'b1; v[3:0] = 4'(nr);
      end else if (rel == off + 1) begin
         v[14] = 1'b1; v[13] = 1'b1; v[12] = 1'b1; v[11:10] = op ? 2'd2 : 2'd1;
      end else if (rel == off + 2) begin
         v[8] = 1'b1; v[14] = 1'b1; v[12] = 1'b1; v[5] = op; v[4] = 1'b1;
      end else if (rel >= off + 3 && rel <= off + nr + 1) begin
         v[14] = 1'b1; v[12] = 1'b1; v[5] = op; v[4] = 1'b1; v[3:0] = 4'(rel - off - 2);
      end else if (idx <= outidx) begin
         v[7] = 1'b1; v[6] = (idx == outidx); v[3:0] = 4'(nr);
      end else begin
         v[15] = 1'b1;
      end
      return v;
   endfunction

   function automatic string tag_at(int idx, int base, bit pre, int nr, int outidx,
                                    bit man, bit second);
      int rel = idx - base;
      int off = pre ? nr + 2 : 0;
      if (second && idx <= outidx)      return "R11";
      if (pre && rel <= nr + 2)         return "R7/R6";
      if (rel == off + 1)               return "R2/R8";
      if (rel == off + 2)               return "R3/R6";
      if (rel <= off + nr + 1)          return "R4/R6";
      if (idx < outidx)                 return "R9";
      if (idx == outidx)                return man ? "R10" : "R5";
      return "R12";
   endfunction

   function automatic logic [15:0] mask_for(logic [15:0] e);
      logic [15:0] m = 16'hFFFF;
      if (!e[12]) m[11:10] = 2'b00;
      if (!e[14]) m[13] = 1'b0;
      if (!e[4])  m[5] = 1'b0;
      if (e[15])  m[3:0] = 4'h0;
      return m;
   endfunction

   task automatic check(logic [15:0] got, logic [15:0] exp, logic [15:0] msk,
                        string tag, int idx);
      checks++;
      if (((got ^ exp) & msk) != 16'h0) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %h expected %h (mask %h)", tag, idx, got, exp, msk);
      end
   endtask

   task automatic run(bit op, logic [1:0] kl, bit knew, bit man, int stall, bit chain);
      int nr = (kl == 2'd0) ? 10 : (kl == 2'd1) ? 12 : 14;
      bit pre1, pre2;
      int out1, out2, last;
      if (kl != last_kl) knew = 1'b1;
      last_kl = kl;
      if (knew) bvalid = 1'b0;
      pre1 = op && !bvalid;
      if (op) bvalid = 1'b1;
      out1 = (pre1 ? nr + 2 : 0) + nr + 2 + (man ? 0 : stall);
      pre2 = op && !bvalid;
      out2 = out1 + (pre2 ? nr + 2 : 0) + nr + 2;
      last = chain ? out2 : out1;
      op_dec = op; key_len = kl; key_new = knew; manual = man; start = 1'b1;
      out_free = man ? 1'b0 : (stall == 0);
      for (int idx = 1; idx <= last + 1; idx++) begin
         logic [15:0] e;
         string t;
         @(negedge clk);
         if (idx == 1) begin start = 1'b0; key_new = 1'b0; end
         if (chain && idx == 3) start = 1'b1;
         if (chain && idx == 4) start = 1'b0;
         if (!man && idx >= out1) out_free = 1'b1;
         #1;
         if (chain && idx > out1) begin
            e = exp_at(idx, out1, pre2, op, nr, out2);
            t = tag_at(idx, out1, pre2, nr, out2, man, 1'b1);
         end else begin
            e = exp_at(idx, 0, pre1, op, nr, out1);
            t = tag_at(idx, 0, pre1, nr, out1, man, 1'b0);
         end
         check(got_vec(), e, mask_for(e), t, idx);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0AE5_5EED));
      repeat (3) @(posedge clk);
      #1;
      check(got_vec(), 16'h8000, 16'hFFFF, "R1", 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(got_vec(), 16'h8000, 16'hFFFF, "R1", 0);
      @(negedge clk);
      #1;
      // Directed corner cases
      run(1'b0, 2'd0, 1'b1, 1'b0, 0, 1'b0); // R8 encryption right after key change
      run(1'b1, 2'd0, 1'b0, 1'b0, 0, 1'b0); // R7 first decryption
      run(1'b1, 2'd0, 1'b0, 1'b0, 0, 1'b0); // R8 saved key reused
      run(1'b0, 2'd1, 1'b0, 1'b0, 2, 1'b0); // R9 stall for two cycles
      run(1'b1, 2'd1, 1'b1, 1'b0, 0, 1'b0); // R7 192-bit precompute
      run(1'b1, 2'd2, 1'b1, 1'b0, 3, 1'b1); // R11 start during precompute
      run(1'b0, 2'd2, 1'b0, 1'b1, 0, 1'b0); // R10 manual mode
      run(1'b1, 2'd2, 1'b0, 1'b1, 0, 1'b1); // R10 R11 manual back-to-back
      // Constrained random mix
      for (int n = 0; n < 40; n++) begin
         run(1'($urandom % 2), 2'($urandom % 3), ($urandom % 4) == 0,
             ($urandom % 4) == 0, int'($urandom % 4), ($urandom % 5) == 0);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule